// File: doc/BRIEF.md
# Register-Port Serial Transceiver with Three-Tick Bit Timing

This block is a byte-wide asynchronous serial transmitter and receiver placed behind a small register port. A host reaches it through three active-low strobes (select, write, read), one address bit and two 8-bit data buses. Address 0 reaches the data register: a write there hands a byte to the transmitter, and a read there returns the most recently received byte. Address 1 returns a status byte. Two status flags are also driven straight out as interrupt lines: "byte waiting" (`rx_irq`) and "transmitter free" (`tx_free`).

Bit timing comes from a 16-bit divider input. One divided tick lasts `baud_div` clock cycles, and each serial bit lasts three ticks, so the bit rate is the clock frequency divided by three times `baud_div`. The receiver samples once on each tick and decides each bit by majority over its three samples. The transmitter and the receiver each contain a small state machine. Transmit states are TX_IDLE, TX_START, TX_DATA and TX_STOP. A data-register write moves TX_IDLE to TX_START, and each state advances on the third tick of its bit. TX_DATA repeats for eight bits and then moves to TX_STOP, which returns to TX_IDLE. Receive states are RX_IDLE, RX_START, RX_DATA and RX_STOP. A low line moves RX_IDLE to RX_START. RX_START returns to RX_IDLE if its middle sample is high, and otherwise moves to RX_DATA after three ticks. RX_DATA holds for eight bits and moves to RX_STOP, which returns to RX_IDLE after three ticks.

Top module: `uart3x_port`

## Requirements
- R1: One bit lasts 3*`baud_div` clock cycles. A frame is one low start bit, eight data bits sent least significant bit first, and one high stop bit. The transmit line is high whenever no frame is being sent.
- R2: A cycle with `cs_n`=0, `wr_n`=0 and `addr`=0 while the transmitter is free loads `wdata`. The start bit begins on the clock edge that captures the write.
- R3: `tx_free` is 0 for the whole 30*`baud_div`-cycle frame and returns to 1 on the edge that ends the stop bit.
- R4: A data-register write made while a frame is in progress has no effect on the frame being sent.
- R5: Each received bit is decided by majority over three samples, one per tick. A disturbance that lasts one tick inside a data bit does not change the received byte.
- R6: A falling edge whose start bit is high again at its middle sample is ignored. No byte is received.
- R7: A frame that ends with a high stop bit sets the byte-waiting flag. A read at `addr`=0 returns the received byte.
- R8: A read of the data register (`cs_n`=0, `rd_n`=0, `addr`=0) clears the byte-waiting flag, unless a new byte completes in the same cycle.
- R9: At `addr`=1, `rdata` bit 0 is byte-waiting and bit 1 is transmitter-free. Bits 7..2 read 0. `rx_irq` and `tx_free` always equal these two bits.
- R10: A byte that completes while the flag is already set replaces the stored byte, and the flag stays set.
- R11: A frame whose stop bit is sampled low is discarded. The stored byte and the flag are unchanged.
- R12: `rst` is active high. While it is held, the transmit line is high, `rx_irq` is 0 and `tx_free` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| ser_tx | output | 1 | Serial transmit line |
| ser_rx | input | 1 | Serial receive line (asynchronous) |
| baud_div | input | 16 | Clock cycles per tick; 0 is treated as 1 |
| cs_n | input | 1 | Port select, active low |
| wr_n | input | 1 | Write strobe, active low |
| rd_n | input | 1 | Read strobe, active low |
| addr | input | 1 | 0 = data register, 1 = status |
| wdata | input | 8 | Byte to transmit |
| rdata | output | 8 | Received byte or status |
| rx_irq | output | 1 | Byte waiting (interrupt) |
| tx_free | output | 1 | Transmitter free (interrupt) |

## Verification
On every cycle the assertions check four things: the transmit line stays high whenever the transmitter is free, each frame start is traced back to a data-register write, the byte-waiting flag sets only on a completed byte and clears after a data read, and the status byte matches the two interrupt lines. Only the bench scenarios can show the rest. That covers the bit-exact serial waveform and its timing, majority voting against a one-tick disturbance, rejection of a short start pulse and of a low stop bit, overrun replacement, and writes dropped while busy, all across several divider values.

// File: rtl/uart3x_pkg.sv
package uart3x_pkg;
    localparam int DATA_W        = 8;
    localparam int DIV_W         = 16;
    localparam int TICKS_PER_BIT = 3;
    localparam int PHASE_W       = $clog2(TICKS_PER_BIT + 1);
    localparam int BITCNT_W      = $clog2(DATA_W);

    typedef enum logic [1:0] {
        TX_IDLE,
        TX_START,
        TX_DATA,
        TX_STOP
    } tx_state_e;

    typedef enum logic [1:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_STOP
    } rx_state_e;
endpackage

// File: rtl/uart3x_tick.sv
module uart3x_tick #(
    parameter int DIV_W     = 16,
    parameter bit HALF_LOAD = 1'b0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [DIV_W-1:0] div,
    input  logic             clr,
    output logic             tick
);
    logic [DIV_W-1:0] lim;
    logic [DIV_W-1:0] cnt;
    logic [DIV_W-1:0] load_val;

    assign lim  = (div == '0) ? DIV_W'(1) : div;
    assign tick = (cnt >= lim - DIV_W'(1));

    generate
        if (HALF_LOAD) begin : g_half
            assign load_val = lim >> 1;
        end else begin : g_zero
            assign load_val = '0;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (clr) begin
            cnt <= load_val;
        end else if (tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + DIV_W'(1);
        end
    end
endmodule

// File: rtl/uart3x_tx.sv
module uart3x_tx
    import uart3x_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              load,
    input  logic [DATA_W-1:0] load_byte,
    output logic              line,
    output logic              busy
);
    tx_state_e            state, nxt;
    logic [PHASE_W-1:0]   phase;
    logic [BITCNT_W-1:0]  bitn;
    logic [DATA_W-1:0]    shreg;
    logic                 last;

    assign last = tick && (phase == PHASE_W'(TICKS_PER_BIT - 1));

    always_comb begin
        nxt = state;
        unique case (state)
            TX_IDLE:  if (load) nxt = TX_START;
            TX_START: if (last) nxt = TX_DATA;
            TX_DATA:  if (last && bitn == BITCNT_W'(DATA_W - 1)) nxt = TX_STOP;
            TX_STOP:  if (last) nxt = TX_IDLE;
            default:  nxt = TX_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= TX_IDLE;
            phase <= '0;
            bitn  <= '0;
            shreg <= '0;
        end else begin
            state <= nxt;
            if (state == TX_IDLE) begin
                if (load) begin
                    shreg <= load_byte;
                    phase <= '0;
                    bitn  <= '0;
                end
            end else if (tick) begin
                if (last) begin
                    phase <= '0;
                    if (state == TX_DATA) begin
                        shreg <= shreg >> 1;
                        bitn  <= bitn + BITCNT_W'(1);
                    end
                end else begin
                    phase <= phase + PHASE_W'(1);
                end
            end
        end
    end

    always_comb begin
        unique case (state)
            TX_START: line = 1'b0;
            TX_DATA:  line = shreg[0];
            default:  line = 1'b1;
        endcase
        busy = (state != TX_IDLE);
    end
endmodule

// File: rtl/uart3x_rx.sv
module uart3x_rx
    import uart3x_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              rx_in,
    input  logic              tick,
    output logic              start_det,
    output logic              done,
    output logic [DATA_W-1:0] rx_byte
);
    rx_state_e            state, nxt;
    logic [1:0]           sync;
    logic                 smp;
    logic [PHASE_W-1:0]   phase;
    logic [BITCNT_W-1:0]  bitn;
    logic [1:0]           ones;
    logic [DATA_W-1:0]    shreg;
    logic                 last;
    logic                 mid;
    logic                 vote;

    assign smp  = sync[1];
    assign last = tick && (phase == PHASE_W'(TICKS_PER_BIT - 1));
    assign mid  = tick && (phase == PHASE_W'(1));
    assign vote = ({1'b0, ones} + {2'b00, smp}) >= 3'd2;

    always_comb begin
        nxt = state;
        unique case (state)
            RX_IDLE:  if (!smp) nxt = RX_START;
            RX_START: begin
                if (mid && smp)  nxt = RX_IDLE;
                else if (last)   nxt = RX_DATA;
            end
            RX_DATA:  if (last && bitn == BITCNT_W'(DATA_W - 1)) nxt = RX_STOP;
            RX_STOP:  if (last) nxt = RX_IDLE;
            default:  nxt = RX_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sync  <= 2'b11;
            state <= RX_IDLE;
            phase <= '0;
            bitn  <= '0;
            ones  <= '0;
            shreg <= '0;
        end else begin
            sync  <= {sync[0], rx_in};
            state <= nxt;
            if (state == RX_IDLE) begin
                phase <= '0;
                bitn  <= '0;
                ones  <= '0;
            end else if (tick) begin
                if (last) begin
                    phase <= '0;
                    ones  <= '0;
                    if (state == RX_DATA) begin
                        shreg <= {vote, shreg[DATA_W-1:1]};
                        bitn  <= bitn + BITCNT_W'(1);
                    end
                end else begin
                    phase <= phase + PHASE_W'(1);
                    ones  <= ones + {1'b0, smp};
                end
            end
        end
    end

    always_comb begin
        start_det = (state == RX_IDLE) && !smp;
        done      = (state == RX_STOP) && last && vote;
        rx_byte   = shreg;
    end
endmodule

// File: rtl/uart3x_port.sv
module uart3x_port
    import uart3x_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    output logic              ser_tx,
    input  logic              ser_rx,
    input  logic [DIV_W-1:0]  baud_div,
    input  logic              cs_n,
    input  logic              wr_n,
    input  logic              rd_n,
    input  logic              addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              rx_irq,
    output logic              tx_free
);
    logic              tx_tick, rx_tick;
    logic              tx_busy, tx_load;
    logic              rx_start, rx_done;
    logic [DATA_W-1:0] rx_byte;
    logic [DATA_W-1:0] data_q;
    logic              full_q;
    logic              wr_hit, rd_hit;

    assign wr_hit  = !cs_n && !wr_n && !addr;
    assign rd_hit  = !cs_n && !rd_n && !addr;
    assign tx_load = wr_hit && !tx_busy;

    uart3x_tick #(.DIV_W(DIV_W), .HALF_LOAD(1'b0)) u_tx_tick (
        .clk(clk), .rst(rst), .div(baud_div), .clr(tx_load), .tick(tx_tick)
    );

    uart3x_tick #(.DIV_W(DIV_W), .HALF_LOAD(1'b1)) u_rx_tick (
        .clk(clk), .rst(rst), .div(baud_div), .clr(rx_start), .tick(rx_tick)
    );

    uart3x_tx u_tx (
        .clk(clk), .rst(rst), .tick(tx_tick), .load(tx_load),
        .load_byte(wdata), .line(ser_tx), .busy(tx_busy)
    );

    uart3x_rx u_rx (
        .clk(clk), .rst(rst), .rx_in(ser_rx), .tick(rx_tick),
        .start_det(rx_start), .done(rx_done), .rx_byte(rx_byte)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            full_q <= 1'b0;
            data_q <= '0;
        end else if (rx_done) begin
            full_q <= 1'b1;
            data_q <= rx_byte;
        end else if (rd_hit) begin
            full_q <= 1'b0;
        end
    end

    always_comb begin
        rx_irq  = full_q;
        tx_free = !tx_busy;
        rdata   = addr ? {{(DATA_W-2){1'b0}}, !tx_busy, full_q} : data_q;
    end
endmodule

// File: rtl/uart3x_port_chk.sv
module uart3x_port_chk (
    input logic       clk,
    input logic       rst,
    input logic       cs_n,
    input logic       wr_n,
    input logic       rd_n,
    input logic       addr,
    input logic [7:0] rdata,
    input logic       ser_tx,
    input logic       rx_irq,
    input logic       tx_free,
    input logic       rx_done
);
    // R1: line idles high while no frame is in flight
    a_r1_idle_line_high: assert property (@(posedge clk) disable iff (rst)
        tx_free |-> ser_tx);

    // R2: every frame start follows a data-register write and opens with a low bit
    a_r2_start_after_write: assert property (@(posedge clk) disable iff (rst)
        $fell(tx_free) |-> (!ser_tx && $past(!cs_n && !wr_n && !addr)));

    // R7: byte-waiting only rises on a completed byte
    a_r7_flag_from_byte: assert property (@(posedge clk) disable iff (rst)
        $rose(rx_irq) |-> $past(rx_done));

    // R8: a data read with no new byte clears the flag
    a_r8_read_clears: assert property (@(posedge clk) disable iff (rst)
        (!cs_n && !rd_n && !addr && !rx_done) |=> !rx_irq);

    // R10: a completed byte always leaves the flag set
    a_r10_byte_sets_flag: assert property (@(posedge clk) disable iff (rst)
        rx_done |=> rx_irq);

    // R9: status byte matches the interrupt lines
    a_r9_status_mirror: assert property (@(posedge clk) disable iff (rst)
        addr |-> (rdata == {6'b0, tx_free, rx_irq}));
endmodule

bind uart3x_port uart3x_port_chk u_chk (
    .clk(clk), .rst(rst), .cs_n(cs_n), .wr_n(wr_n), .rd_n(rd_n),
    .addr(addr), .rdata(rdata), .ser_tx(ser_tx), .rx_irq(rx_irq),
    .tx_free(tx_free), .rx_done(rx_done)
);

// File: tb/uart3x_port_bench.sv
module uart3x_port_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ser_tx;
    logic        ser_rx = 1'b1;
    logic [15:0] baud_div = 16'd8;
    logic        cs_n = 1'b1;
    logic        wr_n = 1'b1;
    logic        rd_n = 1'b1;
    logic        addr = 1'b0;
    logic [7:0]  wdata = 8'h00;
    logic [7:0]  rdata;
    logic        rx_irq;
    logic        tx_free;

    int total = 0;
    int bad   = 0;
    bit finished = 1'b0;
    bit exp_full = 1'b0;
    logic [7:0] exp_data = 8'h00;

    always #4 clk = ~clk;

    uart3x_port u_uart3x_port (
        .clk(clk), .rst(rst), .ser_tx(ser_tx), .ser_rx(ser_rx),
        .baud_div(baud_div), .cs_n(cs_n), .wr_n(wr_n), .rd_n(rd_n),
        .addr(addr), .wdata(wdata), .rdata(rdata), .rx_irq(rx_irq),
        .tx_free(tx_free)
    );

    function automatic bit frame_bit(input logic [7:0] b, input int k);
        if (k == 0) return 1'b0;
        if (k == 9) return 1'b1;
        return b[k-1];
    endfunction

    function automatic logic [7:0] status_of(input bit full, input bit free);
        return {6'b0, free, full};
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic peek(input logic a, output logic [7:0] v);
        @(negedge clk);
        addr = a;
        #1 v = rdata;
    endtask

    task automatic read_data(output logic [7:0] v);
        @(negedge clk);
        addr = 1'b0; cs_n = 1'b0; rd_n = 1'b0;
        #1 v = rdata;
        @(negedge clk);
        cs_n = 1'b1; rd_n = 1'b1;
        exp_full = 1'b0;
    endtask

    // Drive one received frame; glitch_bit >= 0 flips the first tick of that data bit
    task automatic rx_send(input logic [7:0] b, input int glitch_bit, input bit stop_val);
        int d;
        d = int'(baud_div);
        @(negedge clk);
        ser_rx = 1'b0;
        repeat (3*d) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            if (i == glitch_bit) begin
                ser_rx = ~b[i];
                repeat (d) @(negedge clk);
                ser_rx = b[i];
                repeat (2*d) @(negedge clk);
            end else begin
                ser_rx = b[i];
                repeat (3*d) @(negedge clk);
            end
        end
        ser_rx = stop_val;
        repeat (3*d) @(negedge clk);
        ser_rx = 1'b1;
        repeat (3*d) @(negedge clk);
        if (stop_val) begin
            exp_full = 1'b1;
            exp_data = b;
        end
    endtask

    // Write a byte and check the serial waveform bit by bit
    task automatic tx_frame(input logic [7:0] b, input bit inject);
        int d, m, r;
        logic [7:0] st;
        d = int'(baud_div);
        m = (3*d)/2;
        @(negedge clk);
        addr = 1'b0; cs_n = 1'b0; wr_n = 1'b0; wdata = b;
        @(negedge clk);
        cs_n = 1'b1; wr_n = 1'b1;
        repeat (m) @(negedge clk);
        for (int k = 0; k < 10; k++) begin
            chk($sformatf("R1/R2 tx bit %0d", k), int'(ser_tx), int'(frame_bit(b, k)));
            chk("R3 tx_free low in frame", int'(tx_free), 0);
            if (k == 5) begin
                addr = 1'b1;
                #1 st = rdata;
                chk("R9 status during frame", int'(st), int'(status_of(exp_full, 1'b0)));
                chk("R9 irq mirror", int'(rx_irq), int'(exp_full));
                addr = 1'b0;
            end
            if (k < 9) begin
                if (inject && k == 3) begin
                    cs_n = 1'b0; wr_n = 1'b0; wdata = ~b;
                    @(negedge clk);
                    cs_n = 1'b1; wr_n = 1'b1;
                    repeat (3*d - 1) @(negedge clk);
                end else begin
                    repeat (3*d) @(negedge clk);
                end
            end
        end
        r = 3*d - m;
        repeat (r - 1) @(negedge clk);
        chk("R3 tx_free low on last cycle", int'(tx_free), 0);
        @(negedge clk);
        chk("R3 tx_free back high", int'(tx_free), 1);
        chk("R1 line idle high", int'(ser_tx), 1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            bad++;
            total++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        logic [7:0] b1, b2;
        void'($urandom(32'd1234));

        repeat (4) @(negedge clk);
        chk("R12 line high in reset", int'(ser_tx), 1);
        chk("R12 rx_irq low in reset", int'(rx_irq), 0);
        chk("R12 tx_free high in reset", int'(tx_free), 1);
        peek(1'b1, v);
        chk("R12 status in reset", int'(v), int'(status_of(1'b0, 1'b1)));
        rst = 1'b0;
        repeat (3) @(negedge clk);

        // Directed: transmit corner bytes, one with a write while busy
        tx_frame(8'h55, 1'b0);
        tx_frame(8'h80, 1'b1);     // R4 second write ignored
        repeat (30) @(negedge clk);
        chk("R4 no second frame after ignored write", int'(tx_free), 1);
        chk("R4 line stays idle", int'(ser_tx), 1);

        // R6: short start pulse rejected
        @(negedge clk);
        ser_rx = 1'b0;
        repeat (int'(baud_div)) @(negedge clk);
        ser_rx = 1'b1;
        repeat (6*int'(baud_div)) @(negedge clk);
        chk("R6 glitch start gives no byte", int'(rx_irq), 0);

        // R7, R8: clean receive then read
        rx_send(8'hA5, -1, 1'b1);
        chk("R7 flag set after frame", int'(rx_irq), 1);
        peek(1'b1, v);
        chk("R9 status with byte waiting", int'(v), int'(status_of(1'b1, 1'b1)));
        read_data(v);
        chk("R7 data read returns byte", int'(v), 8'hA5);
        chk("R8 read clears flag", int'(rx_irq), 0);

        // R11: low stop bit discards frame
        rx_send(8'h3C, -1, 1'b0);
        chk("R11 flag unchanged on bad stop", int'(rx_irq), 0);
        peek(1'b0, v);
        chk("R11 stored byte unchanged", int'(v), 8'hA5);

        // R10: overrun replaces byte
        rx_send(8'h11, -1, 1'b1);
        rx_send(8'hEE, -1, 1'b1);
        chk("R10 flag stays set", int'(rx_irq), 1);
        read_data(v);
        chk("R10 newest byte kept", int'(v), 8'hEE);
        chk("R8 cleared after overrun read", int'(rx_irq), 0);

        // R11 with flag already set: old byte and flag survive
        rx_send(8'h42, -1, 1'b1);
        rx_send(8'h99, -1, 1'b0);
        chk("R11 flag kept on bad stop", int'(rx_irq), 1);
        read_data(v);
        chk("R11 earlier byte kept", int'(v), 8'h42);

        // Random mix over divider values with one-tick disturbances
        for (int i = 0; i < 16; i++) begin
            int gl;
            baud_div = 16'(8 + 2*($urandom % 3));
            b1 = 8'($urandom);
            b2 = 8'($urandom);
            gl = (($urandom % 2) == 0) ? int'($urandom % 8) : -1;
            rx_send(b1, gl, 1'b1);
            chk("R7 random flag", int'(rx_irq), 1);
            read_data(v);
            chk($sformatf("R5 random byte glitch=%0d", gl), int'(v), int'(b1));
            chk("R8 random clear", int'(rx_irq), 0);
            tx_frame(b2, (i % 4) == 0);
        end

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule